// File: doc/BRIEF.md
# Bidirectional Binary RBM Tile

This block is one small, fully parallel tile of a restricted Boltzmann machine. It holds an N×N array of signed weights, plus one bias per visible neuron and one per hidden neuron, in registers local to the tile. On a start strobe it takes N binary neuron states and forms all N×N gated products at once. It then reduces each column with an adder tree, adds the bias for that output neuron, and registers the N signed pre-activation sums.

A single direction bit selects the propagation. In visible-to-hidden mode the stored matrix is used as written. In hidden-to-visible mode a triangular net of controlled-swap cells exchanges each off-diagonal weight pair, so the same product and adder datapath sees the transposed matrix. Diagonal weights feed through untouched. Binary states make every multiply a gate: a state of 1 passes the weight and a state of 0 passes zero. Sigmoid, sampling, data movement between tiles and the learning update all sit outside this block.

Top module: `rbm_tile`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sum_valid` goes to 0, `sum_out` goes to 0, and every weight and bias goes to 0, so a start after reset returns all-zero sums.
- R2: `sum_valid` is 1 in exactly the cycle after each cycle in which `start` is 1, and is 0 otherwise.
- R3: With `dir`=0 (visible to hidden), output j equals hbias[j] + Σ_i state_in[i]·w[i][j]. Output j is the 11-bit signed field `sum_out[j*11 +: 11]`.
- R4: With `dir`=1 (hidden to visible), output i equals vbias[i] + Σ_j state_in[j]·w[i][j], using the same output field layout.
- R5: A state bit of 0 contributes zero whatever its weights are. An all-zero `state_in` yields exactly the direction's bias vector.
- R6: The diagonal weights w[k][k] contribute identically in both directions. With only diagonal weights and zero biases, both directions give the same sums for the same input.
- R7: A write with `wr_en`=1 acts by `wr_kind`. Value 0 stores w[row][col], where row=`wr_addr[3:2]` and col=`wr_addr[1:0]`. Value 1 stores vbias[`wr_addr[1:0]`]. Value 2 stores hbias[`wr_addr[1:0]`]. Value 3 changes nothing.
- R8: A write presented in a cycle where `start` is 1 is ignored.
- R9: Sums never wrap. All weights and biases at -128 with every state at 1 give -640, and all at 127 give 635.
- R10: `sum_out` holds its value in every cycle without `start`, whatever `state_in` and `dir` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch one computation using this cycle's `dir` and `state_in` |
| dir | input | 1 | 0: visible to hidden, 1: hidden to visible |
| state_in | input | 4 | Binary neuron states of the source layer, bit k = neuron k |
| wr_en | input | 1 | Write strobe for weights and biases |
| wr_kind | input | 2 | Write target: 0 weight, 1 visible bias, 2 hidden bias, 3 none |
| wr_addr | input | 4 | Weight row in [3:2] and column in [1:0]; bias index in [1:0] |
| wr_data | input | 8 | Signed value to store |
| sum_out | output | 44 | Four 11-bit signed sums, output k in bits [k*11 +: 11] |
| sum_valid | output | 1 | High for the one cycle in which `sum_out` carries a new result |

## Verification
A swap cell that is stuck, or driven by the wrong control, leaves the matrix untransposed in one direction. That error appears at the next valid result as a wrong sum on the two outputs that share the affected off-diagonal pair, and the direction with asymmetric weights exposes it. A corrupted weight or bias register, or a write that slipped through while a start was in progress, shows on the first later result whose input enables that row, or at once in the bias under an all-zero input. A broken product gate or adder node gives a wrong sum in the first cycle after start.

// File: rtl/rbm_tile_pkg.sv
// Package: shared encodings for the RBM tile.
// Assumes: nothing beyond IEEE 1800-2017.
package rbm_tile_pkg;

    // Target of a write on the parameter port.
    typedef enum logic [1:0] {
        WK_WEIGHT = 2'b00,
        WK_VBIAS  = 2'b01,
        WK_HBIAS  = 2'b10,
        WK_NONE   = 2'b11
    } wr_kind_e;

    // Propagation direction.
    typedef enum logic {
        DIR_V2H = 1'b0,
        DIR_H2V = 1'b1
    } dir_e;

endpackage

// File: rtl/rbm_weight_store.sv
// Module: local parameter storage of one tile.
// Holds an N x N signed weight array, N visible biases and N hidden biases.
// A write addresses row/column of the weight array, or a bias index in the
// low address bits. Assumes N is a power of two. A write in a cycle where
// 'blocked' is high is dropped. Values are exposed as flat packed buses,
// element (r,c) at bits [(r*N+c)*WW +: WW].
module rbm_weight_store
    import rbm_tile_pkg::*;
#(
    parameter int N  = 4,
    parameter int WW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              blocked,
    input  logic [1:0]        wr_kind,
    input  logic [2*$clog2(N)-1:0] wr_addr,
    input  logic [WW-1:0]     wr_data,
    output logic [N*N*WW-1:0] w_flat,
    output logic [N*WW-1:0]   vbias_flat,
    output logic [N*WW-1:0]   hbias_flat
);
    localparam int IW = $clog2(N);

    logic [WW-1:0] w_q     [N][N];
    logic [WW-1:0] vbias_q [N];
    logic [WW-1:0] hbias_q [N];

    logic [IW-1:0] row_idx;
    logic [IW-1:0] col_idx;
    logic          wr_ok;

    // Decode the address fields and the write qualification.
    always_comb begin
        row_idx = wr_addr[2*IW-1:IW];
        col_idx = wr_addr[IW-1:0];
        wr_ok   = wr_en && !blocked;
    end

    // Parameter registers: clear on reset, update on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++) begin
                vbias_q[r] <= '0;
                hbias_q[r] <= '0;
                for (int c = 0; c < N; c++) begin
                    w_q[r][c] <= '0;
                end
            end
        end else if (wr_ok) begin
            case (wr_kind_e'(wr_kind))
                WK_WEIGHT: w_q[row_idx][col_idx] <= wr_data;
                WK_VBIAS:  vbias_q[col_idx]      <= wr_data;
                WK_HBIAS:  hbias_q[col_idx]      <= wr_data;
                default:   ;
            endcase
        end
    end

    // Flatten storage onto the output buses.
    for (genvar r = 0; r < N; r++) begin : g_row
        assign vbias_flat[r*WW +: WW] = vbias_q[r];
        assign hbias_flat[r*WW +: WW] = hbias_q[r];
        for (genvar c = 0; c < N; c++) begin : g_col
            assign w_flat[(r*N+c)*WW +: WW] = w_q[r][c];
        end
    end

    // R8: a write that coincides with a start leaves every stored value intact.
    p_write_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && blocked) |=> ($stable(w_flat) && $stable(vbias_flat) && $stable(hbias_flat)))
        else $error("write during start changed storage");

    // R7: the unused write kind changes nothing.
    p_kind_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == 2'b11) |=> ($stable(w_flat) && $stable(vbias_flat) && $stable(hbias_flat)))
        else $error("write of kind none changed storage");

endmodule

// File: rtl/rbm_swap_cell.sv
// Module: one controlled-swap cell.
// With ctl low the two operands pass straight; with ctl high they trade
// places. Purely combinational; assumes nothing about operand content.
module rbm_swap_cell #(
    parameter int WW = 8
) (
    input  logic          ctl,
    input  logic [WW-1:0] a_in,
    input  logic [WW-1:0] b_in,
    output logic [WW-1:0] a_out,
    output logic [WW-1:0] b_out
);
    // Route each operand to its straight or crossed output.
    always_comb begin
        a_out = ctl ? b_in : a_in;
        b_out = ctl ? a_in : b_in;
    end
endmodule

// File: rtl/rbm_swap_net.sv
// Module: in-place transpose network.
// Places one swap cell on every off-diagonal pair (r<c), (N*N-N)/2 cells in
// total, all driven by the direction bit. Diagonal elements pass through.
// Output element (r,c) feeds product row r of output column c.
module rbm_swap_net #(
    parameter int N  = 4,
    parameter int WW = 8
) (
    input  logic              dir,
    input  logic [N*N*WW-1:0] w_flat,
    output logic [N*N*WW-1:0] sel_flat
);
    for (genvar r = 0; r < N; r++) begin : g_r
        for (genvar c = 0; c < N; c++) begin : g_c
            if (r == c) begin : g_diag
                // Diagonal weight is its own transpose.
                assign sel_flat[(r*N+c)*WW +: WW] = w_flat[(r*N+c)*WW +: WW];
            end else if (r < c) begin : g_pair
                // One cell serves both elements of the mirrored pair.
                rbm_swap_cell #(.WW(WW)) u_cell (
                    .ctl   (dir),
                    .a_in  (w_flat[(r*N+c)*WW +: WW]),
                    .b_in  (w_flat[(c*N+r)*WW +: WW]),
                    .a_out (sel_flat[(r*N+c)*WW +: WW]),
                    .b_out (sel_flat[(c*N+r)*WW +: WW])
                );
            end
        end
    end
endmodule

// File: rtl/rbm_mac_column.sv
// Module: gated products and adder tree for one output neuron.
// Each binary state gates its weight (state 1 passes it, 0 passes zero);
// a balanced tree sums the N sign-extended products, then the bias is added.
// Assumes N is a power of two and SW is wide enough for N+1 extreme terms.
module rbm_mac_column #(
    parameter int N  = 4,
    parameter int WW = 8,
    parameter int SW = 11
) (
    input  logic [N-1:0]    state,
    input  logic [N*WW-1:0] w_col,
    input  logic [WW-1:0]   bias,
    output logic [SW-1:0]   sum
);
    localparam int NODES = 2*N - 1;

    logic [SW-1:0] node [NODES];

    // Leaves: gated, sign-extended products.
    for (genvar r = 0; r < N; r++) begin : g_leaf
        logic [WW-1:0] wv;
        assign wv = w_col[r*WW +: WW];
        assign node[N-1+r] = state[r] ? {{(SW-WW){wv[WW-1]}}, wv} : '0;
    end

    // Inner nodes: each adds its two children.
    for (genvar k = 0; k < N-1; k++) begin : g_node
        assign node[k] = node[2*k+1] + node[2*k+2];
    end

    // Root plus sign-extended bias.
    assign sum = node[0] + {{(SW-WW){bias[WW-1]}}, bias};
endmodule

// File: rtl/rbm_tile.sv
// Module: bidirectional binary RBM tile (top).
// Local weight and bias storage, a transpose swap net selected by 'dir', one
// gated adder tree per output, and a result register. A start launches one
// computation; the registered sums and a one-cycle valid appear on the
// next cycle. Writes in a start cycle are ignored. Sync active-low reset.
module rbm_tile
    import rbm_tile_pkg::*;
#(
    parameter int N  = 4,
    parameter int WW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          dir,
    input  logic [N-1:0]                  state_in,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_kind,
    input  logic [2*$clog2(N)-1:0]        wr_addr,
    input  logic [WW-1:0]                 wr_data,
    output logic [N*(WW+$clog2(N)+1)-1:0] sum_out,
    output logic                          sum_valid
);
    localparam int IW    = $clog2(N);
    localparam int SW    = WW + IW + 1;
    localparam int LO_BD = -(N + 1) * (2 ** (WW - 1));
    localparam int HI_BD = (N + 1) * (2 ** (WW - 1) - 1);

    logic [N*N*WW-1:0] w_flat;
    logic [N*N*WW-1:0] sel_flat;
    logic [N*WW-1:0]   vbias_flat;
    logic [N*WW-1:0]   hbias_flat;
    logic [N*WW-1:0]   bias_flat;
    logic [N*SW-1:0]   sum_d;
    logic [N*SW-1:0]   sum_q;
    logic              valid_q;

    rbm_weight_store #(.N(N), .WW(WW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .blocked    (start),
        .wr_kind    (wr_kind),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .w_flat     (w_flat),
        .vbias_flat (vbias_flat),
        .hbias_flat (hbias_flat)
    );

    rbm_swap_net #(.N(N), .WW(WW)) u_swap (
        .dir      (dir),
        .w_flat   (w_flat),
        .sel_flat (sel_flat)
    );

    // Bias of the destination layer: hidden for dir 0, visible for dir 1.
    assign bias_flat = (dir == DIR_H2V) ? vbias_flat : hbias_flat;

    for (genvar c = 0; c < N; c++) begin : g_out
        logic [N*WW-1:0] col_w;
        // Gather column c of the routed matrix, one element per source row.
        for (genvar r = 0; r < N; r++) begin : g_gather
            assign col_w[r*WW +: WW] = sel_flat[(r*N+c)*WW +: WW];
        end
        rbm_mac_column #(.N(N), .WW(WW), .SW(SW)) u_col (
            .state (state_in),
            .w_col (col_w),
            .bias  (bias_flat[c*WW +: WW]),
            .sum   (sum_d[c*SW +: SW])
        );

        // R5: an all-zero input yields exactly the bias of that output.
        p_bias_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (start && state_in == '0) |=>
                ($signed(sum_out[c*SW +: SW]) == $signed($past(bias_flat[c*WW +: WW]))))
            else $error("zero input did not give bias");

        // R9: a valid sum always lies in the reachable range, never wrapped.
        p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
            sum_valid |-> (($signed(sum_out[c*SW +: SW]) >= LO_BD) &&
                           ($signed(sum_out[c*SW +: SW]) <= HI_BD)))
            else $error("sum out of range");
    end

    // Result register: capture sums on start, pulse valid one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= start;
            if (start) begin
                sum_q <= sum_d;
            end
        end
    end

    assign sum_out   = sum_q;
    assign sum_valid = valid_q;

    // R1: reset clears the result and the valid flag.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!sum_valid && sum_out == '0))
        else $error("reset did not clear outputs");

    // R2: valid follows a start by one cycle.
    p_valid_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> sum_valid)
        else $error("valid missing after start");

    // R2: no valid without a start in the cycle before.
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !sum_valid)
        else $error("valid without start");

    // R10: the result holds between starts.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(sum_out))
        else $error("sum changed without start");

endmodule

// File: tb/tb_rbm_tile.sv
`timescale 1ns/1ps
module tb_rbm_tile;
    localparam int N  = 4;
    localparam int WW = 8;
    localparam int SW = 11;
    localparam int NV = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            dir = 1'b0;
    logic [N-1:0]    state_in = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_kind = '0;
    logic [3:0]      wr_addr = '0;
    logic [WW-1:0]   wr_data = '0;
    logic [N*SW-1:0] sum_out;
    logic            sum_valid;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rbm_tile #(.N(N), .WW(WW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .state_in(state_in),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .sum_out(sum_out), .sum_valid(sum_valid)
    );

    // Weight matrix w[row=visible][col=hidden]; vbias i+1, hbias -(j+1).
    localparam int W_INIT [4][4] = '{'{1, 2, 3, 4}, '{10, 20, 30, 40},
                                     '{-5, -6, -7, -8}, '{100, -100, 50, -50}};
    // Stimulus {dir, state[3:0]} and expected outputs 0..3.
    localparam logic [4:0] STIM [NV] = '{5'b0_0001, 5'b0_1111, 5'b0_1010, 5'b1_0001,
                                         5'b1_1111, 5'b1_0110, 5'b0_0000, 5'b1_0000};
    localparam int EXP [NV][4] = '{'{0, 0, 0, 0}, '{105, -86, 73, -18}, '{109, -82, 77, -14},
                                   '{2, 12, -2, 104}, '{11, 102, -23, 4}, '{6, 52, -10, -46},
                                   '{-1, -2, -3, -4}, '{1, 2, 3, 4}};

    task automatic check_sum(input string tag, input int k, input int exp);
        int act;
        act = $signed(sum_out[k*SW +: SW]);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s out%0d actual=%0d expected=%0d", tag, k, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] kind, input logic [3:0] addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = kind; wr_addr = addr; wr_data = WW'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Launch one computation; on return the result is on the outputs.
    task automatic run(input logic d, input logic [N-1:0] st);
        @(negedge clk);
        start = 1'b1; dir = d; state_in = st;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_all(input string tag, input int e0, input int e1, input int e2, input int e3);
        check_sum(tag, 0, e0); check_sum(tag, 1, e1);
        check_sum(tag, 2, e2); check_sum(tag, 3, e3);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        failures++;
        $display("FAIL R2 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R1: reset state.
        repeat (3) @(negedge clk);
        check_bit("R1 valid in reset", sum_valid, 1'b0);
        check_all("R1 sums in reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        run(1'b0, 4'b1111);
        check_all("R1 zero storage", 0, 0, 0, 0);
        check_bit("R2 valid after start", sum_valid, 1'b1);
        @(negedge clk);
        check_bit("R2 valid one cycle", sum_valid, 1'b0);

        // Load parameters (R7 addressing: {row,col}, bias index in [1:0]).
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                wr(2'b00, 4'(r*4 + c), W_INIT[r][c]);
        for (int i = 0; i < 4; i++) begin
            wr(2'b01, 4'(i), i + 1);
            wr(2'b10, 4'(i), -(i + 1));
        end

        // Vector table: R3 for dir 0, R4 for dir 1, R5 for all-zero input.
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = (STIM[v][3:0] == 4'b0) ? "R5" : (STIM[v][4] ? "R4" : "R3");
            run(STIM[v][4], STIM[v][3:0]);
            for (int k = 0; k < 4; k++) check_sum(tag, k, EXP[v][k]);
        end

        // R8: write during start is dropped.
        @(negedge clk);
        start = 1'b1; dir = 1'b0; state_in = 4'b0001;
        wr_en = 1'b1; wr_kind = 2'b00; wr_addr = 4'h0; wr_data = 8'd77;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        run(1'b0, 4'b0001);
        check_all("R8 write in start ignored", 0, 0, 0, 0);

        // R7: kind 3 changes nothing.
        wr(2'b11, 4'h0, 99);
        wr(2'b11, 4'h5, 99);
        run(1'b0, 4'b0011);
        check_all("R7 kind none weights", 10, 20, 30, 40);
        run(1'b1, 4'b0000);
        check_all("R7 kind none vbias", 1, 2, 3, 4);

        // R10: hold between starts while inputs wander.
        @(negedge clk); dir = 1'b0; state_in = 4'b1111;
        repeat (3) @(negedge clk);
        check_all("R10 hold", 1, 2, 3, 4);
        check_bit("R10 no valid", sum_valid, 1'b0);

        // R6: diagonal only, zero biases, both directions agree.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < 4; k++) wr(2'b00, 4'(k*5), (k + 1) * 7);
        run(1'b0, 4'b1101);
        check_all("R6 diag v2h", 7, 0, 21, 28);
        run(1'b1, 4'b1101);
        check_all("R6 diag h2v", 7, 0, 21, 28);

        // R9: extremes.
        for (int a = 0; a < 16; a++) wr(2'b00, 4'(a), -128);
        for (int i = 0; i < 4; i++) begin
            wr(2'b01, 4'(i), -128);
            wr(2'b10, 4'(i), -128);
        end
        run(1'b0, 4'b1111);
        check_all("R9 min", -640, -640, -640, -640);
        for (int a = 0; a < 16; a++) wr(2'b00, 4'(a), 127);
        for (int i = 0; i < 4; i++) begin
            wr(2'b01, 4'(i), 127);
            wr(2'b10, 4'(i), 127);
        end
        run(1'b1, 4'b1111);
        check_all("R9 max", 635, 635, 635, 635);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule